// File: doc/BRIEF.md
# Program Flow Sequencer for an 8-bit Harvard Controller

This block steers instruction fetch for a small 8-bit controller whose program and data spaces are separate. It owns a 12-bit program counter that is never visible to data accesses, a return stack held in dedicated registers, and the carry and zero flags. Each accepted instruction byte, with its optional second byte, is classified here. Relative branches, absolute jumps and calls, subroutine and interrupt returns, and the two halt opcodes are executed in this block. Every other opcode belongs to the rest of the core, and the PC simply advances by the length that the outer decoder reports.

The flags live in three banks, one for each processor mode: normal, interrupt and non-maskable interrupt. An external ALU writes flag results into the bank of the mode in effect, and the flag outputs always show that bank. Entering an interrupt saves the current PC together with the current mode in one stack frame. An interrupt return brings both back, so the earlier flag bank becomes visible again with its contents unchanged.

Interrupt requests are sampled every cycle. An accepted request wins over the instruction presented in the same cycle. That instruction is discarded, including its flag write, and is fetched again after the return because its own address is the one saved.

Top module: `pc_sequencer`

## Requirements
- R1: After reset, fetch_addr is RESET_VEC (default 0x000), mode is 0 (normal), flag_c and flag_z are 0, halted, clk_stop and stack_err are 0.
- R2: An accepted byte with bit 0 = 0 is a relative branch. Bits 7:3 are a signed displacement. Bit 1 picks the flag (0 = zero, 1 = carry) and bit 2 the polarity (1 = branch when the flag is 1, 0 = branch when it is 0). A taken branch goes to PC+1+displacement modulo 4096; otherwise the next address is PC+1.
- R3: An accepted byte with bits 2:0 = 001 is an absolute transfer to {byte[7:4], op_arg}. Bit 3 = 1 is a plain jump. Bit 3 = 0 is a call, which also pushes PC+2 with the current mode.
- R4: Byte 0xCD pops a frame and continues at its PC. Byte 0x4D pops a frame and also restores its mode.
- R5: Any other accepted byte advances the PC by op_len. When op_valid is 0 and no interrupt is taken, the PC holds.
- R6: An ALU flag write (alu_flag_we with an accepted byte) updates only the bank of the current mode (0 normal, 1 interrupt, 2 NMI). flag_c and flag_z show the current mode's bank.
- R7: nmi is taken in any mode except 2, and irq only in mode 0. nmi has priority. Taking either pushes the current PC and mode, jumps to NMI_VEC (0xFFC) or IRQ_VEC (0xFF4), sets mode 2 or 1, and discards the byte and flag write offered in that cycle.
- R8: Byte 0x6D (stop) and byte 0xED (wait) advance the PC by 1 and set halted; clk_stop is also set for 0x6D only. While halted, accepted bytes have no effect. A taken interrupt clears halted and clk_stop.
- R9: The stack holds DEPTH frames (4 by default, 6 supported). A push on a full stack or a pop on an empty one sets a sticky stack_err, and the stack level saturates. A call on a full stack still jumps. A return on an empty stack advances the PC by 1 and keeps the mode.
- R10: Frames come back in last-in first-out order across nested calls and interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An instruction byte is presented at fetch_addr this cycle |
| op_code | input | 8 | Instruction byte |
| op_arg | input | 8 | Byte following the instruction byte |
| op_len | input | 2 | Length in bytes of an opcode not handled here |
| alu_flag_we | input | 1 | ALU writes carry and zero this cycle |
| alu_c | input | 1 | Carry value from the ALU |
| alu_z | input | 1 | Zero value from the ALU |
| irq | input | 1 | Maskable interrupt request |
| nmi | input | 1 | Non-maskable interrupt request |
| fetch_addr | output | 12 | Program counter, address of the next fetch |
| flag_c | output | 1 | Carry of the active bank |
| flag_z | output | 1 | Zero of the active bank |
| mode | output | 2 | Current mode: 0 normal, 1 interrupt, 2 NMI |
| halted | output | 1 | Core halted by a stop or wait byte |
| clk_stop | output | 1 | Halt with the clock stopped |
| stack_err | output | 1 | Sticky stack overflow or underflow |

## Verification
Interrupt acceptance can coincide with an instruction that would itself push a frame, write flags or leave the halt state. The bench forces an irq in the same cycle as a call with a flag write, and an nmi in the same cycle as an irq. It then checks that only the interrupt frame was pushed, that the flag banks kept their values, and that the later return resumes at the discarded instruction. The same overlaps recur under random stimulus, where a bench model with its own stack and banks judges every cycle.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int PC_W = 12;

  typedef enum logic [1:0] {
    MODE_NORM = 2'd0,
    MODE_IRQ  = 2'd1,
    MODE_NMI  = 2'd2
  } mode_e;

  typedef enum logic [2:0] {
    K_OTHER,
    K_BRANCH,
    K_CALL,
    K_JUMP,
    K_RET,
    K_RETI,
    K_STOP,
    K_WAIT
  } kind_e;

  typedef struct packed {
    logic [PC_W-1:0] pc;
    mode_e           mode;
  } frame_t;

  localparam logic [7:0] OPC_RET  = 8'hCD;
  localparam logic [7:0] OPC_RETI = 8'h4D;
  localparam logic [7:0] OPC_STOP = 8'h6D;
  localparam logic [7:0] OPC_WAIT = 8'hED;
endpackage

// File: rtl/pcs_decode.sv
module pcs_decode
  import pcs_pkg::*;
(
  input  logic [7:0]      op_code,
  output kind_e           kind,
  output logic [PC_W-1:0] disp,
  output logic            flag_sel,
  output logic            polarity,
  output logic [3:0]      abs_hi
);
  localparam int DISP_W = 5;

  always_comb begin
    if (!op_code[0]) begin
      kind = K_BRANCH;
    end else if (op_code[2:0] == 3'b001) begin
      kind = op_code[3] ? K_JUMP : K_CALL;
    end else begin
      unique case (op_code)
        OPC_RET:  kind = K_RET;
        OPC_RETI: kind = K_RETI;
        OPC_STOP: kind = K_STOP;
        OPC_WAIT: kind = K_WAIT;
        default:  kind = K_OTHER;
      endcase
    end
  end

  assign disp     = {{(PC_W-DISP_W){op_code[7]}}, op_code[7:3]};
  assign flag_sel = op_code[1];
  assign polarity = op_code[2];
  assign abs_hi   = op_code[7:4];
endmodule

// File: rtl/pcs_stack.sv
module pcs_stack
  import pcs_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   push,
  input  logic   pop,
  input  frame_t wdata,
  output frame_t top,
  output logic   empty,
  output logic   full,
  output logic   err
);
  localparam int SP_W = $clog2(DEPTH + 1);

  logic [SP_W-1:0] sp_q, sp_d;
  logic            err_q, err_d;
  frame_t          mem_q [DEPTH];
  logic [DEPTH-1:0] wr_en;

  assign empty = (sp_q == '0);
  assign full  = (sp_q == SP_W'(DEPTH));

  always_comb begin
    sp_d  = sp_q;
    err_d = err_q;
    if (push) begin
      if (full) err_d = 1'b1;
      else      sp_d  = sp_q + 1'b1;
    end else if (pop) begin
      if (empty) err_d = 1'b1;
      else       sp_d  = sp_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= '0;
      err_q <= 1'b0;
    end else begin
      sp_q  <= sp_d;
      err_q <= err_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign wr_en[g] = push && !full && (sp_q == SP_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g] <= '0;
      end else if (wr_en[g]) begin
        mem_q[g] <= wdata;
      end
    end
  end

  always_comb begin
    top = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (sp_q == SP_W'(i + 1)) top = mem_q[i];
    end
  end

  assign err = err_q;
endmodule

// File: rtl/pcs_flagbank.sv
module pcs_flagbank
  import pcs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_e sel,
  input  logic  we,
  input  logic  c_in,
  input  logic  z_in,
  output logic  c_out,
  output logic  z_out
);
  localparam int NBANK = 3;

  logic [NBANK-1:0] c_q, z_q;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit = we && (sel == mode_e'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        c_q[b] <= 1'b0;
        z_q[b] <= 1'b0;
      end else if (hit) begin
        c_q[b] <= c_in;
        z_q[b] <= z_in;
      end
    end
  end

  always_comb begin
    c_out = 1'b0;
    z_out = 1'b0;
    for (int i = 0; i < NBANK; i++) begin
      if (sel == mode_e'(i)) begin
        c_out = c_q[i];
        z_out = z_q[i];
      end
    end
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcs_pkg::*;
#(
  parameter int              DEPTH     = 4,
  parameter logic [PC_W-1:0] RESET_VEC = 12'h000,
  parameter logic [PC_W-1:0] IRQ_VEC   = 12'hFF4,
  parameter logic [PC_W-1:0] NMI_VEC   = 12'hFFC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [7:0]      op_code,
  input  logic [7:0]      op_arg,
  input  logic [1:0]      op_len,
  input  logic            alu_flag_we,
  input  logic            alu_c,
  input  logic            alu_z,
  input  logic            irq,
  input  logic            nmi,
  output logic [PC_W-1:0] fetch_addr,
  output logic            flag_c,
  output logic            flag_z,
  output logic [1:0]      mode,
  output logic            halted,
  output logic            clk_stop,
  output logic            stack_err
);
  logic [PC_W-1:0] pc_q, pc_d;
  mode_e           mode_q, mode_d;
  logic            halt_q, halt_d;
  logic            stop_q, stop_d;

  kind_e           kind;
  logic [PC_W-1:0] disp;
  logic            flag_sel, polarity;
  logic [3:0]      abs_hi;

  logic            push, pop;
  frame_t          push_frame, top;
  logic            stk_empty, stk_full;
  logic            cur_c, cur_z;
  logic            flag_we;

  logic            take_nmi, take_irq, exec, br_taken;
  logic [PC_W-1:0] seq1, seq2, abs_tgt;

  pcs_decode u_dec (
    .op_code  (op_code),
    .kind     (kind),
    .disp     (disp),
    .flag_sel (flag_sel),
    .polarity (polarity),
    .abs_hi   (abs_hi)
  );

  pcs_stack #(.DEPTH(DEPTH)) u_stk (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pop   (pop),
    .wdata (push_frame),
    .top   (top),
    .empty (stk_empty),
    .full  (stk_full),
    .err   (stack_err)
  );

  pcs_flagbank u_flg (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (mode_q),
    .we    (flag_we),
    .c_in  (alu_c),
    .z_in  (alu_z),
    .c_out (cur_c),
    .z_out (cur_z)
  );

  assign take_nmi = nmi && (mode_q != MODE_NMI);
  assign take_irq = irq && (mode_q == MODE_NORM) && !take_nmi;
  assign exec     = op_valid && !halt_q && !take_nmi && !take_irq;
  assign seq1     = pc_q + PC_W'(1);
  assign seq2     = pc_q + PC_W'(2);
  assign abs_tgt  = {abs_hi, op_arg};
  assign br_taken = ((flag_sel ? cur_c : cur_z) == polarity);

  always_comb begin
    pc_d       = pc_q;
    mode_d     = mode_q;
    halt_d     = halt_q;
    stop_d     = stop_q;
    push       = 1'b0;
    pop        = 1'b0;
    push_frame = '{pc: pc_q, mode: mode_q};
    flag_we    = 1'b0;
    if (take_nmi || take_irq) begin
      push   = 1'b1;
      pc_d   = take_nmi ? NMI_VEC : IRQ_VEC;
      mode_d = take_nmi ? MODE_NMI : MODE_IRQ;
      halt_d = 1'b0;
      stop_d = 1'b0;
    end else if (exec) begin
      flag_we = alu_flag_we;
      unique case (kind)
        K_BRANCH: pc_d = br_taken ? (seq1 + disp) : seq1;
        K_CALL: begin
          push          = 1'b1;
          push_frame.pc = seq2;
          pc_d          = abs_tgt;
        end
        K_JUMP: pc_d = abs_tgt;
        K_RET: begin
          pop  = 1'b1;
          pc_d = stk_empty ? seq1 : top.pc;
        end
        K_RETI: begin
          pop = 1'b1;
          if (stk_empty) begin
            pc_d = seq1;
          end else begin
            pc_d   = top.pc;
            mode_d = top.mode;
          end
        end
        K_STOP: begin
          pc_d   = seq1;
          halt_d = 1'b1;
          stop_d = 1'b1;
        end
        K_WAIT: begin
          pc_d   = seq1;
          halt_d = 1'b1;
        end
        default: pc_d = pc_q + PC_W'(op_len);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= RESET_VEC;
      mode_q <= MODE_NORM;
      halt_q <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      mode_q <= mode_d;
      halt_q <= halt_d;
      stop_q <= stop_d;
    end
  end

  assign fetch_addr = pc_q;
  assign flag_c     = cur_c;
  assign flag_z     = cur_z;
  assign mode       = mode_q;
  assign halted     = halt_q;
  assign clk_stop   = stop_q;
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
  parameter logic [11:0] IRQ_VEC = 12'hFF4,
  parameter logic [11:0] NMI_VEC = 12'hFFC
) (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [7:0]  op_code,
  input logic [7:0]  op_arg,
  input logic        alu_flag_we,
  input logic        irq,
  input logic        nmi,
  input logic [11:0] fetch_addr,
  input logic        flag_c,
  input logic        flag_z,
  input logic [1:0]  mode,
  input logic        halted,
  input logic        clk_stop,
  input logic        stack_err
);
  logic nmi_in, irq_in, any_in;
  assign nmi_in = nmi && (mode != 2'd2);
  assign irq_in = irq && (mode == 2'd0) && !nmi_in;
  assign any_in = nmi_in || irq_in;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stack_err |=> stack_err); // R9

  AST_NMI_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_in |=> (fetch_addr == NMI_VEC) && (mode == 2'd2) && !halted); // R7

  AST_IRQ_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_in |=> (fetch_addr == IRQ_VEC) && (mode == 2'd1) && !halted); // R7

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !any_in) |=> $stable(fetch_addr) && halted); // R8

  AST_STOP_IN_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stop |-> halted); // R8

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !halted && !any_in && op_code[3:0] == 4'b1001)
      |=> fetch_addr == {$past(op_code[7:4]), $past(op_arg)}); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !any_in) |=> $stable(fetch_addr)); // R5

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !alu_flag_we && !any_in) |=> $stable(flag_c) && $stable(flag_z)); // R6
endmodule

bind pc_sequencer pcs_checker #(.IRQ_VEC(IRQ_VEC), .NMI_VEC(NMI_VEC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_valid    (op_valid),
  .op_code     (op_code),
  .op_arg      (op_arg),
  .alu_flag_we (alu_flag_we),
  .irq         (irq),
  .nmi         (nmi),
  .fetch_addr  (fetch_addr),
  .flag_c      (flag_c),
  .flag_z      (flag_z),
  .mode        (mode),
  .halted      (halted),
  .clk_stop    (clk_stop),
  .stack_err   (stack_err)
);

// File: tb/pc_sequencer_test.sv
`timescale 1ns/1ps
module pc_sequencer_test;
  localparam int          DEPTH   = 4;
  localparam logic [11:0] IRQ_V   = 12'hFF4;
  localparam logic [11:0] NMI_V   = 12'hFFC;
  localparam real         CLK_P   = 8.0;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid, alu_flag_we, alu_c, alu_z, irq, nmi;
  logic [7:0]  op_code, op_arg;
  logic [1:0]  op_len;
  logic [11:0] fetch_addr;
  logic        flag_c, flag_z, halted, clk_stop, stack_err;
  logic [1:0]  mode;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic [11:0] m_pc;
  int          m_mode, m_sp;
  logic [11:0] m_spc [8];
  int          m_smd [8];
  logic        m_bc [3];
  logic        m_bz [3];
  logic        m_halt, m_stop, m_err;

  always #(CLK_P/2) clk = ~clk;

  pc_sequencer #(.DEPTH(DEPTH), .RESET_VEC(12'h000), .IRQ_VEC(IRQ_V), .NMI_VEC(NMI_V)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .op_arg(op_arg),
    .op_len(op_len), .alu_flag_we(alu_flag_we), .alu_c(alu_c), .alu_z(alu_z),
    .irq(irq), .nmi(nmi), .fetch_addr(fetch_addr), .flag_c(flag_c), .flag_z(flag_z),
    .mode(mode), .halted(halted), .clk_stop(clk_stop), .stack_err(stack_err)
  );

  function automatic logic [11:0] sext5(input logic [4:0] d);
    return {{7{d[4]}}, d};
  endfunction

  task automatic m_push(input logic [11:0] pc, input int md);
    if (m_sp == DEPTH) m_err = 1'b1;
    else begin
      m_spc[m_sp] = pc;
      m_smd[m_sp] = md;
      m_sp++;
    end
  endtask

  task automatic model_reset();
    m_pc = 12'h000; m_mode = 0; m_sp = 0; m_halt = 0; m_stop = 0; m_err = 0;
    for (int i = 0; i < 3; i++) begin m_bc[i] = 0; m_bz[i] = 0; end
  endtask

  task automatic model_step();
    logic tn, ti, f;
    tn = nmi && (m_mode != 2);
    ti = irq && (m_mode == 0) && !tn;
    if (tn || ti) begin
      m_push(m_pc, m_mode);
      m_pc = tn ? NMI_V : IRQ_V;
      m_mode = tn ? 2 : 1;
      m_halt = 0; m_stop = 0;
    end else if (op_valid && !m_halt) begin
      int old_mode;
      old_mode = m_mode;
      if (!op_code[0]) begin
        f = op_code[1] ? m_bc[m_mode] : m_bz[m_mode];
        m_pc = (f == op_code[2]) ? m_pc + 12'd1 + sext5(op_code[7:3]) : m_pc + 12'd1;
      end else if (op_code[2:0] == 3'b001) begin
        if (!op_code[3]) m_push(m_pc + 12'd2, m_mode);
        m_pc = {op_code[7:4], op_arg};
      end else if (op_code == 8'hCD || op_code == 8'h4D) begin
        if (m_sp == 0) begin
          m_err = 1; m_pc = m_pc + 12'd1;
        end else begin
          m_sp--;
          m_pc = m_spc[m_sp];
          if (op_code == 8'h4D) m_mode = m_smd[m_sp];
        end
      end else if (op_code == 8'h6D || op_code == 8'hED) begin
        m_pc = m_pc + 12'd1; m_halt = 1; m_stop = (op_code == 8'h6D);
      end else begin
        m_pc = m_pc + 12'(op_len);
      end
      if (alu_flag_we) begin m_bc[old_mode] = alu_c; m_bz[old_mode] = alu_z; end
    end
  endtask

  task automatic check_all(input string tag);
    checks++;
    if (fetch_addr !== m_pc || mode !== 2'(m_mode) || flag_c !== m_bc[m_mode] ||
        flag_z !== m_bz[m_mode] || halted !== m_halt || clk_stop !== m_stop ||
        stack_err !== m_err) begin
      errors++;
      $display("FAIL %s: pc=%h mode=%0d c=%b z=%b h=%b cs=%b err=%b | expected pc=%h mode=%0d c=%b z=%b h=%b cs=%b err=%b",
               tag, fetch_addr, mode, flag_c, flag_z, halted, clk_stop, stack_err,
               m_pc, m_mode, m_bc[m_mode], m_bz[m_mode], m_halt, m_stop, m_err);
    end
  endtask

  task automatic idle_inputs();
    op_valid = 0; op_code = 8'h00; op_arg = 8'h00; op_len = 2'd1;
    alu_flag_we = 0; alu_c = 0; alu_z = 0; irq = 0; nmi = 0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset state");
  endtask

  // drive one cycle at a falling edge, advance the model, check at the next falling edge
  task automatic step(input logic v, input logic [7:0] op, input logic [7:0] arg,
                      input logic [1:0] len, input logic we, input logic c, input logic z,
                      input logic ir, input logic nm, input string tag);
    op_valid = v; op_code = op; op_arg = arg; op_len = len;
    alu_flag_we = we; alu_c = c; alu_z = z; irq = ir; nmi = nm;
    model_step();
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    do_reset();
    // absolute transfers
    step(1, 8'h39, 8'h45, 1, 0, 0, 0, 0, 0, "R3 jump 0x345");
    step(1, 8'h71, 8'hA0, 1, 0, 0, 0, 0, 0, "R3 call 0x7A0");
    step(1, 8'hCD, 8'h00, 1, 0, 0, 0, 0, 0, "R4 return to 0x347");
    // flag write, then branches on it
    step(1, 8'h1F, 8'h00, 1, 1, 1, 0, 0, 0, "R6 flag write normal bank");
    step(1, 8'hE6, 8'h00, 1, 0, 0, 0, 0, 0, "R2 carry-set branch taken backward");
    step(1, 8'h1C, 8'h00, 1, 0, 0, 0, 0, 0, "R2 zero-set branch not taken");
    step(1, 8'h1F, 8'h00, 3, 0, 0, 0, 0, 0, "R5 advance by length 3");
    step(0, 8'h39, 8'h00, 1, 1, 0, 1, 0, 0, "R5 no byte holds pc");
    step(1, 8'h09, 8'h00, 1, 0, 0, 0, 0, 0, "R3 jump 0x000");
    step(1, 8'h80, 8'h00, 1, 0, 0, 0, 0, 0, "R2 zero-clear branch wraps below zero");
    // irq collides with call and flag write
    step(1, 8'h21, 8'h10, 1, 1, 0, 1, 1, 0, "R7 irq wins over call and flag write");
    step(1, 8'h1F, 8'h00, 1, 1, 0, 1, 0, 0, "R6 flag write interrupt bank");
    step(1, 8'h1F, 8'h00, 1, 0, 0, 0, 1, 0, "R7 irq ignored in interrupt mode");
    step(1, 8'h1F, 8'h00, 1, 0, 0, 0, 1, 1, "R7 nmi nests over interrupt");
    step(1, 8'h1F, 8'h00, 1, 1, 1, 1, 0, 1, "R7 nmi ignored in nmi mode");
    step(1, 8'h4D, 8'h00, 1, 0, 0, 0, 0, 0, "R4 interrupt return to interrupt mode");
    step(1, 8'h4D, 8'h00, 1, 0, 0, 0, 0, 0, "R10 second return resumes discarded call");
    step(1, 8'h21, 8'h10, 1, 0, 0, 0, 0, 0, "R6 normal bank visible again");
    step(1, 8'hCD, 8'h00, 1, 0, 0, 0, 0, 0, "R10 call frame after nesting");
    // halt behaviour
    step(1, 8'h6D, 8'h00, 1, 0, 0, 0, 0, 0, "R8 stop halts with clock stop");
    step(1, 8'h39, 8'h99, 1, 1, 1, 1, 0, 0, "R8 byte ignored while halted");
    step(1, 8'h1F, 8'h00, 1, 0, 0, 0, 1, 0, "R8 irq wakes from stop");
    step(1, 8'h4D, 8'h00, 1, 0, 0, 0, 0, 0, "R4 return after wake");
    step(1, 8'hED, 8'h00, 1, 0, 0, 0, 0, 0, "R8 wait halts with clock running");
    step(1, 8'h1F, 8'h00, 1, 0, 0, 0, 0, 1, "R8 nmi wakes from wait");
    step(1, 8'h4D, 8'h00, 1, 0, 0, 0, 0, 0, "R4 return from nmi to normal");
    // nested calls then overflow and underflow
    for (int i = 0; i < DEPTH; i++)
      step(1, 8'h51 + 8'(i << 4), 8'(i * 16), 1, 0, 0, 0, 0, 0, "R10 nested call");
    step(1, 8'hB1, 8'h77, 1, 0, 0, 0, 0, 0, "R9 call on full stack still jumps");
    for (int i = 0; i < DEPTH; i++)
      step(1, 8'hCD, 8'h00, 1, 0, 0, 0, 0, 0, "R10 unwind in reverse order");
    step(1, 8'hCD, 8'h00, 1, 0, 0, 0, 0, 0, "R9 return on empty stack");
    step(1, 8'h4D, 8'h00, 1, 0, 0, 0, 0, 0, "R9 interrupt return on empty stack");
    // random phase
    for (int blk = 0; blk < 8; blk++) begin
      do_reset();
      for (int n = 0; n < 500; n++) begin
        logic [7:0] op;
        int sel;
        sel = $urandom_range(0, 99);
        if (sel < 30)      op = {$urandom_range(0, 31) > 0 ? 5'($urandom) : 5'd0, 3'($urandom_range(0, 3) << 1)};
        else if (sel < 45) op = {4'($urandom), 1'($urandom), 3'b001};
        else if (sel < 55) op = 8'hCD;
        else if (sel < 62) op = 8'h4D;
        else if (sel < 64) op = ($urandom_range(0, 1) != 0) ? 8'h6D : 8'hED;
        else               op = 8'h1F;
        step($urandom_range(0, 9) != 0, op, 8'($urandom), 2'($urandom), 1'($urandom),
             1'($urandom), 1'($urandom), $urandom_range(0, 24) == 0,
             $urandom_range(0, 79) == 0, "R10 random mix");
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule